// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block produces the system reset for a chip from three causes. The first is a digitised supply-good flag from an analog comparator. The second is an external reset request, accepted on an active-high pin and on an active-low pin. The third is a watchdog that expects activity on a kick input. The reset is driven in both polarities. The block also drives a write-inhibit level that guards a non-volatile memory against writes while the supply is low.

A drop of the supply flag must last a minimum number of clock cycles before it counts. Shorter dips are treated as glitches and ignored. Once every reset cause has gone away, the reset is held for a further stretch interval before it is released. While an external request is asserted, the stretch starts again from zero. The watchdog counts only while reset is released and is cleared for as long as reset is asserted. Any edge on the kick input restarts it, and a configuration input can switch it off. All intervals are parameters counted in system clock cycles.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high and after it falls, the block starts with the supply taken as low: `sys_rst`=1, `sys_rst_n`=0 and `wr_inhibit`=1.
- R2: When `supply_ok` goes low and stays low for GLITCH_CYC consecutive cycles, `wr_inhibit` rises after GLITCH_CYC cycles and `sys_rst` rises after GLITCH_CYC+1 cycles.
- R3: A low pulse on `supply_ok` that is shorter than GLITCH_CYC cycles changes neither `sys_rst` nor `wr_inhibit`.
- R4: With no other cause present, `sys_rst` falls STRETCH_CYC+1 cycles after `supply_ok` returns high.
- R5: `ext_rst_hi`=1 or `ext_rst_lo_n`=0 asserts `sys_rst` one cycle later. `sys_rst` falls STRETCH_CYC cycles after the last cycle in which either request was active. A request made during the stretch restarts the stretch.
- R6: With `wd_en`=1 and no kick edge, `sys_rst` rises WD_CYC+1 cycles after the watchdog begins counting. It then falls STRETCH_CYC cycles later.
- R7: Either a rising or a falling edge on `wd_kick` restarts the watchdog. `sys_rst` rises WD_CYC+2 cycles after the last edge if no further edge arrives.
- R8: The watchdog is held cleared while `sys_rst` is high. After each release, no watchdog reset occurs earlier than WD_CYC+1 cycles, even if reset had been held for longer than WD_CYC cycles.
- R9: With `wd_en`=0, the watchdog never asserts reset, whatever the kick activity.
- R10: `wr_inhibit` follows only the filtered supply-low state. It falls one cycle after `supply_ok` rises and is not raised by an external or watchdog reset.
- R11: `sys_rst_n` is always the complement of `sys_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high initialisation |
| supply_ok | input | 1 | Supply-good flag from the comparator, synchronous, 1 = above threshold |
| ext_rst_hi | input | 1 | External reset request, active high, level sensitive |
| ext_rst_lo_n | input | 1 | External reset request, active low, level sensitive |
| wd_en | input | 1 | 1 enables the watchdog |
| wd_kick | input | 1 | Activity input; any edge restarts the watchdog |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |
| wr_inhibit | output | 1 | 1 blocks memory writes (supply low) |

## Verification
A stuck or miscounted stretch counter shows as a release of `sys_rst` that comes early or late, measured to the exact cycle from the supply rise or from the end of the external request. A glitch counter that is off by one either lets a dip of GLITCH_CYC-1 cycles reach `sys_rst` and `wr_inhibit`, or delays both by a cycle. A watchdog that is not cleared during reset fires sooner than WD_CYC+1 cycles after a long reset ends. A missed kick edge shows within WD_CYC+2 cycles as an unexpected reset.

// File: rtl/rst_supervisor_pkg.sv
package rst_supervisor_pkg;

    // Causes that hold the system in reset
    typedef struct packed {
        logic supply_low;
        logic ext_req;
        logic wd_bite;
    } rst_cause_t;

    function automatic logic any_cause(input rst_cause_t c);
        return c.supply_low | c.ext_req | c.wd_bite;
    endfunction

    // Counter width for a count that runs 0 .. n-1
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/supply_filter.sv
module supply_filter #(
    parameter int GLITCH_CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    output logic supply_low
);
    import rst_supervisor_pkg::*;

    localparam int CW = cnt_width(GLITCH_CYC);
    localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);

    logic [CW-1:0] low_cnt;
    logic          low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            low_q   <= 1'b1;
        end else if (supply_ok) begin
            low_cnt <= '0;
            low_q   <= 1'b0;
        end else if (!low_q) begin
            if (low_cnt == LAST) begin
                low_q <= 1'b1;
            end else begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    assign supply_low = low_q;

    // R10: a good supply sample always clears the low state next cycle
    a_r10_ok_clears: assert property (@(posedge clk) disable iff (rst)
        supply_ok |=> !supply_low);

    // R3: the low state only appears after a low supply sample
    a_r3_rise_needs_low: assert property (@(posedge clk) disable iff (rst)
        $rose(supply_low) |-> !$past(supply_ok));

endmodule

// File: rtl/reset_stretch.sv
module reset_stretch #(
    parameter int STRETCH_CYC = 40_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic rst_out
);
    import rst_supervisor_pkg::*;

    localparam int CW = cnt_width(STRETCH_CYC);
    localparam logic [CW-1:0] LAST = CW'(STRETCH_CYC - 1);

    logic [CW-1:0] cnt;
    logic          out_q;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt   <= '0;
            out_q <= 1'b1;
        end else if (out_q) begin
            if (cnt == LAST) begin
                cnt   <= '0;
                out_q <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign rst_out = out_q;

    // R4: the stretch counter stays inside its window
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R5: a release is only possible after a cycle with no hold
    a_r5_release_after_quiet: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out) |-> !$past(hold));

endmodule

// File: rtl/activity_watchdog.sv
module activity_watchdog #(
    parameter int WD_CYC = 320_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic sys_rst_i,
    input  logic wd_en,
    input  logic wd_kick,
    output logic bite
);
    import rst_supervisor_pkg::*;

    localparam int CW = cnt_width(WD_CYC);
    localparam logic [CW-1:0] LAST = CW'(WD_CYC - 1);

    logic [CW-1:0] cnt;
    logic          kick_q;
    logic          bite_q;
    logic          kick_edge;

    assign kick_edge = wd_kick ^ kick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            kick_q <= 1'b0;
        end else begin
            kick_q <= wd_kick;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sys_rst_i || !wd_en || kick_edge) begin
            cnt    <= '0;
            bite_q <= 1'b0;
        end else if (cnt == LAST) begin
            cnt    <= '0;
            bite_q <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
            bite_q <= 1'b0;
        end
    end

    assign bite = bite_q;

    // R8: held cleared while the system is in reset
    a_r8_clear_in_reset: assert property (@(posedge clk) disable iff (rst)
        sys_rst_i |=> (cnt == '0) && !bite);

    // R9: disabled watchdog never bites
    a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !wd_en |=> !bite);

    // R7: an activity edge prevents a bite in the next cycle
    a_r7_kick_restarts: assert property (@(posedge clk) disable iff (rst)
        (wd_kick != $past(wd_kick)) |=> !bite);

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int GLITCH_CYC  = 20,
    parameter int STRETCH_CYC = 40_000_000,
    parameter int WD_CYC      = 320_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic ext_rst_hi,
    input  logic ext_rst_lo_n,
    input  logic wd_en,
    input  logic wd_kick,
    output logic sys_rst,
    output logic sys_rst_n,
    output logic wr_inhibit
);
    import rst_supervisor_pkg::*;

    rst_cause_t cause;
    logic       supply_low;
    logic       wd_bite;
    logic       rst_q;

    supply_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filter (
        .clk        (clk),
        .rst        (rst),
        .supply_ok  (supply_ok),
        .supply_low (supply_low)
    );

    activity_watchdog #(.WD_CYC(WD_CYC)) u_wdog (
        .clk       (clk),
        .rst       (rst),
        .sys_rst_i (rst_q),
        .wd_en     (wd_en),
        .wd_kick   (wd_kick),
        .bite      (wd_bite)
    );

    always_comb begin
        cause.supply_low = supply_low;
        cause.ext_req    = ext_rst_hi | ~ext_rst_lo_n;
        cause.wd_bite    = wd_bite;
    end

    reset_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
        .clk     (clk),
        .rst     (rst),
        .hold    (any_cause(cause)),
        .rst_out (rst_q)
    );

    assign sys_rst    = rst_q;
    assign sys_rst_n  = ~rst_q;
    assign wr_inhibit = supply_low;

    // R2: a filtered supply-low state asserts reset next cycle
    a_r2_low_resets: assert property (@(posedge clk) disable iff (rst)
        wr_inhibit |=> sys_rst);

    // R5: an external request on either pin asserts reset next cycle
    a_r5_ext_resets: assert property (@(posedge clk) disable iff (rst)
        (ext_rst_hi || !ext_rst_lo_n) |=> sys_rst);

    // R6: a watchdog bite asserts reset next cycle
    a_r6_bite_resets: assert property (@(posedge clk) disable iff (rst)
        wd_bite |=> sys_rst);

endmodule

// File: tb/tb_rst_supervisor.sv
`timescale 1ns/1ps
module tb_rst_supervisor;

    localparam int G = 3;
    localparam int S = 8;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst, supply_ok, ext_rst_hi, ext_rst_lo_n, wd_en, wd_kick;
    logic sys_rst, sys_rst_n, wr_inhibit;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rst_supervisor #(.GLITCH_CYC(G), .STRETCH_CYC(S), .WD_CYC(W)) dut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok),
        .ext_rst_hi(ext_rst_hi), .ext_rst_lo_n(ext_rst_lo_n),
        .wd_en(wd_en), .wd_kick(wd_kick),
        .sys_rst(sys_rst), .sys_rst_n(sys_rst_n), .wr_inhibit(wr_inhibit)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one clock: returns at the falling edge after the next rising edge
    task automatic tick();
        @(negedge clk);
        check("R11 complement", int'(sys_rst_n), int'(!sys_rst));
    endtask

    // ticks until sys_rst reaches v
    task automatic wait_rst(input logic v, input int limit, output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (sys_rst != v && n < limit);
    endtask

    task automatic quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            tick();
            check(req, int'(sys_rst), 0);
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog timeout");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1; supply_ok = 1'b0; ext_rst_hi = 1'b0; ext_rst_lo_n = 1'b1;
        wd_en = 1'b0; wd_kick = 1'b0;
        repeat (3) tick();
        check("R1 sys_rst", int'(sys_rst), 1);
        check("R1 sys_rst_n", int'(sys_rst_n), 0);
        check("R1 wr_inhibit", int'(wr_inhibit), 1);
        rst = 1'b0;
        repeat (4) tick();
        check("R1 after init sys_rst", int'(sys_rst), 1);
        check("R1 after init wr_inhibit", int'(wr_inhibit), 1);

        // R4 / R10: supply rises
        supply_ok = 1'b1;
        tick();
        check("R10 inhibit clears", int'(wr_inhibit), 0);
        wait_rst(1'b0, 4 * S, n);
        check("R4 release delay", n + 1, S + 1);

        // R3: dips shorter than the glitch width, swept
        for (int d = 1; d < G; d++) begin
            supply_ok = 1'b0;
            for (int i = 0; i < d; i++) tick();
            supply_ok = 1'b1;
            for (int i = 0; i < G + 3; i++) begin
                tick();
                check("R3 sys_rst", int'(sys_rst), 0);
                check("R3 wr_inhibit", int'(wr_inhibit), 0);
            end
        end

        // R2: sustained low, repeated twice
        for (int rep = 0; rep < 2; rep++) begin
            supply_ok = 1'b0;
            for (int i = 1; i <= G + 1; i++) begin
                tick();
                check("R2 inhibit timing", int'(wr_inhibit), int'(i >= G));
                check("R2 reset timing", int'(sys_rst), int'(i >= G + 1));
            end
            supply_ok = 1'b1;
            wait_rst(1'b0, 4 * S, n);
            check("R4 release after dip", n, S + 1);
        end

        // R5 / R10: external requests on both pins, several lengths
        for (int pin = 0; pin < 2; pin++) begin
            for (int d = 1; d <= 4; d++) begin
                if (pin == 0) ext_rst_hi = 1'b1; else ext_rst_lo_n = 1'b0;
                for (int i = 0; i < d; i++) begin
                    tick();
                    check("R5 asserted", int'(sys_rst), 1);
                    check("R10 no inhibit on ext", int'(wr_inhibit), 0);
                end
                ext_rst_hi = 1'b0; ext_rst_lo_n = 1'b1;
                wait_rst(1'b0, 4 * S, n);
                check("R5 release delay", n, S);
            end
        end
        // R5: request during the stretch restarts it
        ext_rst_hi = 1'b1;
        tick();
        ext_rst_hi = 1'b0;
        repeat (3) tick();
        check("R5 mid-stretch still reset", int'(sys_rst), 1);
        ext_rst_lo_n = 1'b0;
        tick();
        ext_rst_lo_n = 1'b1;
        wait_rst(1'b0, 4 * S, n);
        check("R5 restart delay", n, S);

        // R6: watchdog bite and its stretch
        wd_en = 1'b1;
        wait_rst(1'b1, 4 * W, n);
        check("R6 bite delay", n, W + 1);
        check("R10 no inhibit on bite", int'(wr_inhibit), 0);
        wait_rst(1'b0, 4 * S, n);
        check("R6 bite release", n, S);
        // R8: next bite counts from the release
        wait_rst(1'b1, 4 * W, n);
        check("R8 bite after release", n, W + 1);
        wait_rst(1'b0, 4 * S, n);
        check("R6 second release", n, S);

        // R8: long external reset, counter must stay cleared
        ext_rst_hi = 1'b1;
        repeat (3 * W) tick();
        ext_rst_hi = 1'b0;
        wait_rst(1'b0, 4 * S, n);
        check("R5 release after long ext", n, S);
        wait_rst(1'b1, 4 * W, n);
        check("R8 cleared during reset", n, W + 1);
        wait_rst(1'b0, 4 * S, n);

        // R7: kicks of both polarities, swept spacing
        for (int gap = 1; gap <= W - 2; gap += 3) begin
            for (int k = 0; k < 6; k++) begin
                wd_kick = ~wd_kick;
                quiet(gap, "R7 kicked, no reset");
            end
        end
        wd_kick = ~wd_kick;
        wait_rst(1'b1, 4 * W, n);
        check("R7 bite after last edge", n, W + 2);
        wait_rst(1'b0, 4 * S, n);

        // R9: disabled watchdog, with and without kicks
        wd_en = 1'b0;
        quiet(3 * W, "R9 disabled");
        wd_kick = ~wd_kick;
        quiet(3 * W, "R9 disabled after kick");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule